// File: doc/BRIEF.md
# Scanline Table-Driven Register Loader

This block streams small bursts of bytes into peripheral registers once per display line. Each channel walks its own table held in main memory, on what this block calls the A bus. A table entry starts with a line-count byte. Next comes either the burst data itself (direct mode) or a 16-bit little-endian pointer to it (indirect mode). On each line strobe the block may send one burst to consecutive registers on the B bus, then counts the line off. When a run of lines is used up, it fetches the next entry at once.

A frame strobe rearms every channel named in the enable mask and reads each first entry. After that, each line strobe services the live channels one at a time, from the lowest index to the highest. The block holds `busy_o` high until the last channel is done. A line byte of zero retires a channel for the rest of the frame and sets its bit in `ended_o`. Every memory access takes one slot of `SLOT_CLKS` clocks. The A-bus read data must be valid by the last clock of each slot.

Top module: `hdma_seq`

## Requirements
- R1: A frame strobe while idle clears `ended_o` and loads each enabled channel's table address from `tbl_base_i` (bits 23:16 bank, 15:0 address). It then reads that channel's first line byte. Channels not enabled at that strobe make no accesses and no writes for the whole frame.
- R2: A line byte of 0x00 retires the channel. Its `ended_o` bit sets and it makes no further writes until the next frame strobe.
- R3: A nonzero line byte loads a run length from bits 6:0. With bit 7 set, the channel writes on every line of the run. With bit 7 clear, it writes only on the first line of the run.
- R4: The line byte 0x80 gives a run of 128 lines, with a write on every one.
- R5: The burst length for `mode_i` values 0..7 is 1,2,2,4,4,4,2,4 bytes. The register offsets added to `b_addr_i` are:
  - mode 0: 0
  - modes 1 and 5: 0,1 (mode 5 gives 0,1,0,1)
  - modes 2 and 6: 0,0
  - modes 3 and 7: 0,0,1,1
  - mode 4: 0,1,2,3
- R6: With `indirect_i` set, the two bytes after a nonzero line byte form a little-endian data pointer, and the table address moves past them. Burst bytes are read from bank `ind_bank_i` at that pointer.
- R7: After a line that wrote, the data pointer advances by the burst length. In direct mode this is the table address, in indirect mode the pointer.
- R8: When a run ends, the next line byte is read during the same line's service, so a zero there sets the `ended_o` bit before `busy_o` falls.
- R9: Within one strobe, channels are serviced strictly in ascending index order, and at most one channel retires per clock.
- R10: Each A-bus access holds `rd_req_o` for `SLOT_CLKS` clocks. Burst writes occur only on a slot's last clock. A single direct channel with a one-byte burst and no run end stays busy for `SLOT_CLKS`+3 clocks.
- R11: After reset, `busy_o`, `rd_req_o`, `wr_en_o` and `ended_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame-start strobe, one clock |
| line_i | input | 1 | Line strobe, one clock |
| en_i | input | NCH | Channel enable mask, sampled at frame start |
| tbl_base_i | input | NCH×24 | Per-channel table bank and address |
| indirect_i | input | NCH | Per-channel indirect-mode select |
| ind_bank_i | input | NCH×8 | Per-channel bank for indirect data |
| mode_i | input | NCH×3 | Per-channel burst mode |
| b_addr_i | input | NCH×8 | Per-channel base B-bus register |
| rd_req_o | output | 1 | A-bus read active |
| rd_addr_o | output | 24 | A-bus read address |
| rd_data_i | input | 8 | A-bus read data |
| wr_en_o | output | 1 | B-bus write strobe |
| wr_addr_o | output | 8 | B-bus register address |
| wr_data_o | output | 8 | B-bus write data |
| busy_o | output | 1 | Sequencer servicing a strobe |
| ended_o | output | NCH | Channels retired this frame |

## Verification
On every clock, the assertions check that:
- writes occur only inside a read slot;
- an idle block makes no bus activity;
- `ended_o` holds while idle and clears on a frame strobe;
- no more than one channel retires per clock.

Only the bench scenarios can show the byte-level behaviour. This covers the burst order and register offsets of each mode, and indirect pointer and bank selection. It also covers the first-line versus every-line runs, the 128-line run, retirement at the exact line and the busy duration. These come from a scoreboard of expected register writes built from hand-laid tables.

// File: rtl/hdma_pkg.sv
package hdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_NEXT, ST_LINE, ST_PLO, ST_PHI, ST_BURST, ST_ADV
  } seq_state_e;

  function automatic logic [2:0] burst_len(input logic [2:0] m);
    case (m)
      3'd0:                burst_len = 3'd1;
      3'd1, 3'd2, 3'd6:    burst_len = 3'd2;
      default:             burst_len = 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] b_off(input logic [2:0] m, input logic [1:0] k);
    case (m)
      3'd1, 3'd5: b_off = {1'b0, k[0]};
      3'd3, 3'd7: b_off = {1'b0, k[1]};
      3'd4:       b_off = k;
      default:    b_off = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/hdma_slot_timer.sv
module hdma_slot_timer #(
  parameter int SLOT_CLKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic last_o
);
  localparam int W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;

  logic [W-1:0] cnt;

  assign last_o = run_i && (cnt == W'(SLOT_CLKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt <= '0;
    else if (!run_i || last_o) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hdma_pick_lowest.sv
module hdma_pick_lowest #(
  parameter int N = 8,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask_i,
  output logic [CW-1:0] idx_o,
  output logic          any_o
);
  assign any_o = |mask_i;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = CW'(i);
    end
  end
endmodule

// File: rtl/hdma_seq.sv
module hdma_seq
  import hdma_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int SLOT_CLKS = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  frame_i,
  input  logic                  line_i,
  input  logic [NCH-1:0]        en_i,
  input  logic [NCH-1:0][23:0]  tbl_base_i,
  input  logic [NCH-1:0]        indirect_i,
  input  logic [NCH-1:0][7:0]   ind_bank_i,
  input  logic [NCH-1:0][2:0]   mode_i,
  input  logic [NCH-1:0][7:0]   b_addr_i,
  output logic                  rd_req_o,
  output logic [23:0]           rd_addr_o,
  input  logic [7:0]            rd_data_i,
  output logic                  wr_en_o,
  output logic [7:0]            wr_addr_o,
  output logic [7:0]            wr_data_o,
  output logic                  busy_o,
  output logic [NCH-1:0]        ended_o
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  seq_state_e state;
  logic             frame_phase;
  logic [NCH-1:0]   pending, active, do_xfer, every;
  logic [15:0]      work_addr [NCH];
  logic [15:0]      ind_ptr   [NCH];
  logic [7:0]       run_cnt   [NCH];
  logic [CW-1:0]    cur, pick_idx;
  logic             pick_any;
  logic [1:0]       beat;
  logic [7:0]       ptr_lo;
  logic             slot_run, slot_last;

  hdma_slot_timer #(.SLOT_CLKS(SLOT_CLKS)) u_timer (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(slot_run), .last_o(slot_last)
  );

  hdma_pick_lowest #(.N(NCH)) u_pick (
    .mask_i(pending), .idx_o(pick_idx), .any_o(pick_any)
  );

  logic [2:0]  cur_mode, cur_len;
  logic [15:0] data_addr;
  logic [7:0]  data_bank;

  assign cur_mode  = mode_i[cur];
  assign cur_len   = burst_len(cur_mode);
  assign data_addr = (indirect_i[cur] ? ind_ptr[cur] : work_addr[cur]) + 16'(beat);
  assign data_bank = indirect_i[cur] ? ind_bank_i[cur] : tbl_base_i[cur][23:16];

  assign slot_run  = (state == ST_LINE) || (state == ST_PLO) ||
                     (state == ST_PHI)  || (state == ST_BURST);
  assign rd_req_o  = slot_run;
  assign rd_addr_o = (state == ST_BURST) ? {data_bank, data_addr}
                                         : {tbl_base_i[cur][23:16], work_addr[cur]};
  assign wr_en_o   = (state == ST_BURST) && slot_last;
  assign wr_addr_o = b_addr_i[cur] + 8'(b_off(cur_mode, beat));
  assign wr_data_o = rd_data_i;
  assign busy_o    = (state != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= ST_IDLE;
      frame_phase <= 1'b0;
      pending     <= '0;
      active      <= '0;
      ended_o     <= '0;
      do_xfer     <= '0;
      every       <= '0;
      cur         <= '0;
      beat        <= '0;
      ptr_lo      <= '0;
      for (int i = 0; i < NCH; i++) begin
        work_addr[i] <= '0;
        ind_ptr[i]   <= '0;
        run_cnt[i]   <= '0;
      end
    end else begin
      case (state)
        ST_IDLE: begin
          if (frame_i) begin
            frame_phase <= 1'b1;
            pending     <= en_i;
            active      <= en_i;
            ended_o     <= '0;
            do_xfer     <= '0;
            for (int i = 0; i < NCH; i++) begin
              if (en_i[i]) work_addr[i] <= tbl_base_i[i][15:0];
            end
            state <= ST_NEXT;
          end else if (line_i) begin
            frame_phase <= 1'b0;
            pending     <= active;
            state       <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (!pick_any) begin
            state <= ST_IDLE;
          end else begin
            cur               <= pick_idx;
            pending[pick_idx] <= 1'b0;
            beat              <= '0;
            if (frame_phase)            state <= ST_LINE;
            else if (do_xfer[pick_idx]) state <= ST_BURST;
            else                        state <= ST_ADV;
          end
        end
        ST_LINE: begin
          if (slot_last) begin
            work_addr[cur] <= work_addr[cur] + 16'd1;
            if (rd_data_i == 8'h00) begin
              active[cur]  <= 1'b0;
              ended_o[cur] <= 1'b1;
              do_xfer[cur] <= 1'b0;
              state        <= ST_NEXT;
            end else begin
              run_cnt[cur] <= (rd_data_i[6:0] == 7'd0) ? 8'd128 : {1'b0, rd_data_i[6:0]};
              every[cur]   <= rd_data_i[7];
              do_xfer[cur] <= 1'b1;
              state        <= indirect_i[cur] ? ST_PLO : ST_NEXT;
            end
          end
        end
        ST_PLO: begin
          if (slot_last) begin
            ptr_lo         <= rd_data_i;
            work_addr[cur] <= work_addr[cur] + 16'd1;
            state          <= ST_PHI;
          end
        end
        ST_PHI: begin
          if (slot_last) begin
            ind_ptr[cur]   <= {rd_data_i, ptr_lo};
            work_addr[cur] <= work_addr[cur] + 16'd1;
            state          <= ST_NEXT;
          end
        end
        ST_BURST: begin
          if (slot_last) begin
            if ({1'b0, beat} == cur_len - 3'd1) state <= ST_ADV;
            else                                beat  <= beat + 2'd1;
          end
        end
        ST_ADV: begin
          if (do_xfer[cur]) begin
            if (indirect_i[cur]) ind_ptr[cur]   <= ind_ptr[cur]   + 16'(cur_len);
            else                 work_addr[cur] <= work_addr[cur] + 16'(cur_len);
          end
          do_xfer[cur] <= every[cur];
          run_cnt[cur] <= run_cnt[cur] - 8'd1;
          if (run_cnt[cur] == 8'd1) begin
            frame_phase <= 1'b0;
            state       <= ST_LINE;
          end else begin
            state <= ST_NEXT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hdma_seq_chk.sv
module hdma_seq_chk #(
  parameter int NCH = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           frame_i,
  input logic           busy_o,
  input logic           rd_req_o,
  input logic           wr_en_o,
  input logic [NCH-1:0] ended_o
);
  assert_wr_in_slot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (rd_req_o && busy_o));

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!rd_req_o && !wr_en_o));

  assert_ended_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !frame_i) |=> $stable(ended_o));

  assert_frame_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && frame_i) |=> (ended_o == '0));

  assert_one_retire_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ended_o & ~$past(ended_o)) <= 1);
endmodule

bind hdma_seq hdma_seq_chk #(.NCH(NCH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .frame_i (frame_i),
  .busy_o  (busy_o),
  .rd_req_o(rd_req_o),
  .wr_en_o (wr_en_o),
  .ended_o (ended_o)
);

// File: tb/hdma_seq_test.sv
module hdma_seq_test;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic                 frame_s = 1'b0, line_s = 1'b0;
  logic [NCH-1:0]       en = '0;
  logic [NCH-1:0][23:0] tbl_base = '0;
  logic [NCH-1:0]       indir = '0;
  logic [NCH-1:0][7:0]  ind_bank = '0;
  logic [NCH-1:0][2:0]  mode_sel = '0;
  logic [NCH-1:0][7:0]  b_base = '0;
  logic                 rd_req, wr_en, busy;
  logic [23:0]          rd_addr;
  logic [7:0]           rd_data, wr_addr, wr_data;
  logic [NCH-1:0]       ended;

  logic [7:0] mem [4096];
  assign rd_data = mem[{rd_addr[16], rd_addr[10:0]}];

  hdma_seq #(.NCH(NCH), .SLOT_CLKS(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame_s), .line_i(line_s), .en_i(en),
    .tbl_base_i(tbl_base), .indirect_i(indir), .ind_bank_i(ind_bank),
    .mode_i(mode_sel), .b_addr_i(b_base), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .busy_o(busy), .ended_o(ended)
  );

  int n_checks = 0, n_fail = 0;
  string cur_req = "R5";
  logic [15:0] expq[$];

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic bank, input logic [15:0] a, input logic [7:0] v);
    mem[{bank, a[10:0]}] = v;
  endtask

  task automatic expect_wr(input logic [7:0] a, input logic [7:0] d);
    expq.push_back({a, d});
  endtask

  // monitor: compare each register write with the scoreboard
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (expq.size() == 0) begin
        check({cur_req, " unexpected write"}, {wr_addr, wr_data}, 16'hxxxx);
      end else begin
        check(cur_req, {wr_addr, wr_data}, expq.pop_front());
      end
    end
  end

  task automatic strobe(input bit is_frame, output int busy_clks);
    @(negedge clk);
    if (is_frame) frame_s = 1'b1; else line_s = 1'b1;
    @(negedge clk);
    frame_s = 1'b0; line_s = 1'b0;
    busy_clks = 0;
    while (busy) begin
      busy_clks++;
      @(negedge clk);
    end
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    int bc;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 busy", busy, 0);
    check("R11 ended", ended, 0);
    check("R11 bus", {rd_req, wr_en}, 0);
    rst_n = 1'b1;

    // ---- scenario 1: direct mode 1, indirect mode 0, one disabled
    poke(0, 16'h0100, 8'h02); poke(0, 16'h0101, 8'h11); poke(0, 16'h0102, 8'h22);
    poke(0, 16'h0103, 8'h81); poke(0, 16'h0104, 8'h33); poke(0, 16'h0105, 8'h44);
    poke(0, 16'h0106, 8'h00);
    poke(0, 16'h0200, 8'h83); poke(0, 16'h0201, 8'h00); poke(0, 16'h0202, 8'h03);
    poke(0, 16'h0203, 8'h00);
    poke(1, 16'h0300, 8'hA0); poke(1, 16'h0301, 8'hA1); poke(1, 16'h0302, 8'hA2);
    poke(0, 16'h0300, 8'h5A); poke(0, 16'h0301, 8'h5A); poke(0, 16'h0302, 8'h5A);
    poke(0, 16'h0040, 8'h01); poke(0, 16'h0041, 8'h99);
    tbl_base[0] = 24'h000100; mode_sel[0] = 3'd1; b_base[0] = 8'h18;
    tbl_base[1] = 24'h000200; mode_sel[1] = 3'd0; b_base[1] = 8'h22;
    indir[1] = 1'b1; ind_bank[1] = 8'h01;
    tbl_base[2] = 24'h000040; mode_sel[2] = 3'd0; b_base[2] = 8'h77;
    en = 8'b0000_0011;

    cur_req = "R1";
    strobe(1, bc);
    check("R1 ended after frame", ended, 0);
    check("R1 no writes at frame", expq.size(), 0);

    cur_req = "R9 R6 R5";   // ch0 before ch1; indirect bank 1
    expect_wr(8'h18, 8'h11); expect_wr(8'h19, 8'h22); expect_wr(8'h22, 8'hA0);
    strobe(0, bc);
    check("R9 line1 drained", expq.size(), 0);

    cur_req = "R3 R6";      // ch0 first-line-only run: silent on line 2
    expect_wr(8'h22, 8'hA1);
    strobe(0, bc);
    check("R3 line2 drained", expq.size(), 0);
    check("R2 ended line2", ended, 0);

    cur_req = "R7 R8";      // reload at advanced address, every-line entry
    expect_wr(8'h18, 8'h33); expect_wr(8'h19, 8'h44); expect_wr(8'h22, 8'hA2);
    strobe(0, bc);
    check("R7 line3 drained", expq.size(), 0);
    check("R8 ended at run end", ended, 8'b0000_0011);

    cur_req = "R2";         // retired channels stay silent
    strobe(0, bc);
    check("R2 no writes after end", expq.size(), 0);
    check("R2 ended held", ended, 8'b0000_0011);
    check("R1 disabled ch2", ended[2], 0);

    // ---- scenario 2: modes 4, 3, 5, 2 on four channels
    poke(0, 16'h0400, 8'h01);
    for (int i = 0; i < 4; i++) poke(0, 16'h0401 + 16'(i), 8'hB0 + 8'(i));
    poke(0, 16'h0405, 8'h00);
    poke(0, 16'h0500, 8'h01);
    for (int i = 0; i < 4; i++) poke(0, 16'h0501 + 16'(i), 8'hC0 + 8'(i));
    poke(0, 16'h0505, 8'h00);
    poke(0, 16'h0600, 8'h01);
    for (int i = 0; i < 4; i++) poke(0, 16'h0601 + 16'(i), 8'hD0 + 8'(i));
    poke(0, 16'h0605, 8'h00);
    poke(0, 16'h0700, 8'h01); poke(0, 16'h0701, 8'hE0); poke(0, 16'h0702, 8'hE1);
    poke(0, 16'h0703, 8'h00);
    indir = '0;
    tbl_base[0] = 24'h000400; mode_sel[0] = 3'd4; b_base[0] = 8'h40;
    tbl_base[1] = 24'h000500; mode_sel[1] = 3'd3; b_base[1] = 8'h10;
    tbl_base[2] = 24'h000600; mode_sel[2] = 3'd5; b_base[2] = 8'h20;
    tbl_base[3] = 24'h000700; mode_sel[3] = 3'd2; b_base[3] = 8'h30;
    en = 8'b0000_1111;
    cur_req = "R1";
    strobe(1, bc);
    check("R1 ended cleared", ended, 0);
    cur_req = "R5 modes";
    expect_wr(8'h40, 8'hB0); expect_wr(8'h41, 8'hB1); expect_wr(8'h42, 8'hB2); expect_wr(8'h43, 8'hB3);
    expect_wr(8'h10, 8'hC0); expect_wr(8'h10, 8'hC1); expect_wr(8'h11, 8'hC2); expect_wr(8'h11, 8'hC3);
    expect_wr(8'h20, 8'hD0); expect_wr(8'h21, 8'hD1); expect_wr(8'h20, 8'hD2); expect_wr(8'h21, 8'hD3);
    expect_wr(8'h30, 8'hE0); expect_wr(8'h30, 8'hE1);
    strobe(0, bc);
    check("R5 drained", expq.size(), 0);
    check("R8 all ended", ended, 8'b0000_1111);

    // ---- scenario 3: 0x80 entry, 128 every-line writes; timing
    poke(0, 16'h0000, 8'h80);
    for (int i = 0; i < 128; i++) poke(0, 16'h0001 + 16'(i), 8'(i + 1));
    poke(0, 16'h0081, 8'h00);
    tbl_base[0] = 24'h000000; mode_sel[0] = 3'd0; b_base[0] = 8'h05;
    en = 8'b0000_0001;
    cur_req = "R4";
    strobe(1, bc);
    for (int ln = 0; ln < 128; ln++) begin
      expect_wr(8'h05, 8'(ln + 1));
      strobe(0, bc);
      if (ln == 0) check("R10 busy clocks", bc, 11);
      if (ln == 126) check("R4 not ended at 127", ended[0], 0);
    end
    check("R4 ended at 128", ended[0], 1);
    check("R4 drained", expq.size(), 0);

    report();
    $finish;
  end
endmodule